// File: doc/BRIEF.md
# Microinstruction Fetch/Execute Cycle Sequencer

This block paces a small microprogrammed processor. Every machine cycle is split into an instruction phase and an execute phase, and both are measured in base clock pulses, one pulse per clock. The instruction phase always has three fetch cycles. The first fetch cycle copies the instruction address of the active program level into the storage address register. The second reads the microinstruction at that address, from either read/write storage or read-only control storage, and captures it in the operation register. The third writes the address plus two back into the same level's instruction address register.

The execute phase follows. It has one to five cycles, and each is 3 or 8 pulses long. The decoder chooses each cycle's length through a length request and ends the phase with a last-cycle flag. After the fifth execute cycle the phase ends even if the flag was never raised. While the execute phase runs, the datapath owns the memory port, but it can only reach read/write storage.

The block exports the current cycle code and the pulse index within the cycle, so that datapath control can decode them. Each program level keeps its own instruction address register. Every level's register starts from a parameterised start address.

Top module: `ucyc_seq`

## Requirements
- R1: After reset the cycle code is 0 (fetch cycle 1). The pulse index is 0, the operation register is 0, no write-back is signalled and every level's instruction address equals START_ADDR.
- R2: The cycle codes are fetch 1/2/3 = 0/1/2 and execute cycle k = 2+k. Fetch cycles last 3, 8 and 3 pulses. The pulse index counts 0 up to length-1 within each cycle.
- R3: At the end of fetch cycle 1, the storage address register takes the instruction address of the level on `prog_level`. Throughout fetch cycle 2 that value is on `mem_addr` with `mem_rd` high.
- R4: During fetch cycle 2, `mem_rom_sel` follows `src_rom`. On the last pulse of fetch cycle 2, `mem_rdata` is captured into `op_reg`, and `op_reg` holds at all other times.
- R5: On the last pulse of fetch cycle 3, `iar_wr_en` is high and the stored address plus two (modulo 2^AW, so 0xFFFE wraps to 0x0000) is written to the level captured in fetch cycle 1. Later changes of `prog_level` have no effect on that write.
- R6: `ex_long` is sampled at the clock edge that starts each execute cycle. 1 selects 8 pulses and 0 selects 3 pulses.
- R7: If `ex_last` is high on the last pulse of an execute cycle, the next cycle is fetch cycle 1.
- R8: After the fifth execute cycle the sequencer returns to fetch cycle 1 whatever `ex_last` is.
- R9: During execute cycles, `mem_addr` is `ex_addr`, `mem_rd` is `ex_rd` and `mem_rom_sel` is 0 even when `src_rom` is high.
- R10: A write-back changes only its own level's instruction address. Other levels continue from their own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base pulse clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_level | input | LW | Active program level, sampled at end of fetch cycle 1 |
| src_rom | input | 1 | Fetch from read-only control storage when high |
| mem_rdata | input | DW | Read data returned by storage |
| ex_long | input | 1 | Length request for the starting execute cycle (1 = 8 pulses) |
| ex_last | input | 1 | Current execute cycle is the final one |
| ex_rd | input | 1 | Datapath read request during execute |
| ex_addr | input | AW | Datapath address during execute |
| mem_addr | output | AW | Storage address |
| mem_rd | output | 1 | Storage read strobe |
| mem_rom_sel | output | 1 | Selects read-only control storage |
| op_reg | output | DW | Operation register |
| cyc_code | output | 3 | Current cycle code |
| pulse_idx | output | PW | Pulse index within the cycle |
| iar_wr_en | output | 1 | Instruction address write-back strobe |
| iar_wr_lvl | output | LW | Level being written back |
| iar_wr_data | output | AW | Address written back |

## Verification
Some properties are checked on every cycle. The pulse index advances by exactly one or restarts at a cycle end, the fifth execute cycle and a flagged last cycle both lead to fetch cycle 1, and the address register and operation register hold outside their load pulses. Two more are checked throughout: the control-storage select stays low in execute, and a write-back lands only in its target level while every other level stays put. The bench scenarios are needed for the rest. They show the exact 3/8/3 fetch timing and the execute lengths chosen by each request. They also show that addresses continue per level across interleaved levels, the 0xFFFE-to-0x0000 wrap, and recovery from a reset taken in the middle of a fetch.

// File: rtl/ucyc_pkg.sv
`timescale 1ns/1ps
package ucyc_pkg;

  // Cycle codes: fetch cycles first, then execute cycles in order.
  typedef enum logic [2:0] {
    CY_F1 = 3'd0,
    CY_F2 = 3'd1,
    CY_F3 = 3'd2,
    CY_X1 = 3'd3,
    CY_X2 = 3'd4,
    CY_X3 = 3'd5,
    CY_X4 = 3'd6,
    CY_X5 = 3'd7
  } cyc_e;

  function automatic logic in_exec(input cyc_e c);
    return (c >= CY_X1);
  endfunction

  // Pulse length of a cycle; execute cycles use the latched length request.
  function automatic int unsigned cyc_len(input cyc_e c, input logic lng,
                                          input int unsigned f1, input int unsigned f2,
                                          input int unsigned f3, input int unsigned xs,
                                          input int unsigned xl);
    case (c)
      CY_F1:   return f1;
      CY_F2:   return f2;
      CY_F3:   return f3;
      default: return lng ? xl : xs;
    endcase
  endfunction

  // Successor cycle at a cycle boundary.
  function automatic cyc_e next_cyc(input cyc_e c, input logic last, input int unsigned max_x);
    int ord;
    if (!in_exec(c)) return cyc_e'(c + 3'd1);
    ord = int'(c) - int'(CY_X1) + 1;
    if (last || ord >= int'(max_x)) return CY_F1;
    return cyc_e'(c + 3'd1);
  endfunction

endpackage

// File: rtl/ucyc_ctrl.sv
`timescale 1ns/1ps
module ucyc_ctrl
  import ucyc_pkg::*;
#(
  parameter int unsigned F1_LEN = 3,
  parameter int unsigned F2_LEN = 8,
  parameter int unsigned F3_LEN = 3,
  parameter int unsigned XS_LEN = 3,
  parameter int unsigned XL_LEN = 8,
  parameter int unsigned MAX_X  = 5,
  parameter int unsigned PW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_long,
  input  logic          ex_last,
  output cyc_e          cyc,
  output logic [PW-1:0] pulse,
  output logic          cyc_end
);

  cyc_e          cyc_q;
  cyc_e          cyc_d;
  logic [PW-1:0] pcnt_q;
  logic          xlong_q;
  int unsigned   len;

  always_comb begin
    len     = cyc_len(cyc_q, xlong_q, F1_LEN, F2_LEN, F3_LEN, XS_LEN, XL_LEN);
    cyc_end = (pcnt_q == PW'(len - 1));
    cyc_d   = next_cyc(cyc_q, ex_last, MAX_X);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= CY_F1;
      pcnt_q  <= '0;
      xlong_q <= 1'b0;
    end else if (cyc_end) begin
      cyc_q  <= cyc_d;
      pcnt_q <= '0;
      if (in_exec(cyc_d)) xlong_q <= ex_long;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign cyc   = cyc_q;
  assign pulse = pcnt_q;

  // Pulse index steps by one inside a cycle and holds the cycle code.
  assert_pulse_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> (pcnt_q == PW'($past(pcnt_q) + 1'b1)) && (cyc_q == $past(cyc_q)));

  // A cycle boundary restarts the pulse index.
  assert_pulse_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (pcnt_q == '0));

  // Fetch cycles run in fixed order into the first execute cycle.
  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && cyc_q == CY_F3) |=> (cyc_q == CY_X1));

  // A flagged last execute cycle returns to fetch cycle 1.
  assert_last_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && in_exec(cyc_q) && ex_last) |=> (cyc_q == CY_F1));

  // The fifth execute cycle always ends the phase.
  assert_fifth_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && cyc_q == CY_X5) |=> (cyc_q == CY_F1));

endmodule

// File: rtl/ucyc_iar_bank.sv
`timescale 1ns/1ps
module ucyc_iar_bank #(
  parameter int unsigned           NLVL       = 4,
  parameter int unsigned           LW         = 2,
  parameter int unsigned           AW         = 16,
  parameter logic [AW-1:0]         START_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_lvl,
  output logic [AW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lvl,
  input  logic [AW-1:0] wr_data
);

  logic [AW-1:0] iar_q [NLVL];

  always_ff @(posedge clk) begin
    for (int l = 0; l < int'(NLVL); l++) begin
      if (!rst_n) iar_q[l] <= START_ADDR;
      else if (wr_en && wr_lvl == LW'(l)) iar_q[l] <= wr_data;
    end
  end

  assign rd_data = iar_q[rd_lvl];

  // A write-back lands in the addressed level.
  assert_wr_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (iar_q[$past(wr_lvl)] == $past(wr_data)));

  for (genvar g = 0; g < int'(NLVL); g++) begin : g_lvl
    // Levels not addressed by a write keep their value.
    assert_level_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_lvl == LW'(g)) |=> $stable(iar_q[g]));
  end

endmodule

// File: rtl/ucyc_fetch_dp.sv
`timescale 1ns/1ps
module ucyc_fetch_dp
  import ucyc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic          cyc_end,
  input  logic [LW-1:0] prog_level,
  input  logic [AW-1:0] iar_rd,
  input  logic          src_rom,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ex_rd,
  input  logic [AW-1:0] ex_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_rom_sel,
  output logic [DW-1:0] op_reg,
  output logic          wb_en,
  output logic [LW-1:0] wb_lvl,
  output logic [AW-1:0] wb_data
);

  logic [AW-1:0] sar_q;
  logic [LW-1:0] lvl_q;
  logic [DW-1:0] op_q;
  logic          ld_sar;
  logic          ld_op;
  logic          exec_now;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(2);
  endfunction

  assign ld_sar   = (cyc == CY_F1) && cyc_end;
  assign ld_op    = (cyc == CY_F2) && cyc_end;
  assign exec_now = in_exec(cyc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sar_q <= '0;
      lvl_q <= '0;
      op_q  <= '0;
    end else begin
      if (ld_sar) begin
        sar_q <= iar_rd;
        lvl_q <= prog_level;
      end
      if (ld_op) op_q <= mem_rdata;
    end
  end

  assign wb_en   = (cyc == CY_F3) && cyc_end;
  assign wb_lvl  = lvl_q;
  assign wb_data = step_addr(sar_q);

  always_comb begin
    mem_addr    = exec_now ? ex_addr : sar_q;
    mem_rd      = (cyc == CY_F2) || (exec_now && ex_rd);
    mem_rom_sel = (cyc == CY_F2) && src_rom;
  end

  assign op_reg = op_q;

  // Storage address register changes only at the end of fetch cycle 1.
  assert_sar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_sar |=> $stable(sar_q));

  // Operation register changes only at the end of fetch cycle 2.
  assert_op_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_op |=> $stable(op_q));

  // Control storage is never selected in execute cycles.
  assert_exec_no_rom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_now |-> !mem_rom_sel);

endmodule

// File: rtl/ucyc_seq.sv
`timescale 1ns/1ps
module ucyc_seq
  import ucyc_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 16,
  parameter int unsigned   NLVL       = 4,
  parameter logic [AW-1:0] START_ADDR = '0,
  parameter int unsigned   F1_LEN     = 3,
  parameter int unsigned   F2_LEN     = 8,
  parameter int unsigned   F3_LEN     = 3,
  parameter int unsigned   XS_LEN     = 3,
  parameter int unsigned   XL_LEN     = 8,
  parameter int unsigned   MAX_X      = 5,
  localparam int unsigned  LW         = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int unsigned  LMAX_F     = (F1_LEN > F2_LEN) ? ((F1_LEN > F3_LEN) ? F1_LEN : F3_LEN)
                                                          : ((F2_LEN > F3_LEN) ? F2_LEN : F3_LEN),
  localparam int unsigned  LMAX_X     = (XS_LEN > XL_LEN) ? XS_LEN : XL_LEN,
  localparam int unsigned  LMAX       = (LMAX_F > LMAX_X) ? LMAX_F : LMAX_X,
  localparam int unsigned  PW         = (LMAX > 1) ? $clog2(LMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] prog_level,
  input  logic          src_rom,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ex_long,
  input  logic          ex_last,
  input  logic          ex_rd,
  input  logic [AW-1:0] ex_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_rom_sel,
  output logic [DW-1:0] op_reg,
  output logic [2:0]    cyc_code,
  output logic [PW-1:0] pulse_idx,
  output logic          iar_wr_en,
  output logic [LW-1:0] iar_wr_lvl,
  output logic [AW-1:0] iar_wr_data
);

  cyc_e          cyc;
  logic          cyc_end;
  logic [AW-1:0] iar_rd;

  ucyc_ctrl #(
    .F1_LEN(F1_LEN), .F2_LEN(F2_LEN), .F3_LEN(F3_LEN),
    .XS_LEN(XS_LEN), .XL_LEN(XL_LEN), .MAX_X(MAX_X), .PW(PW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ex_long (ex_long),
    .ex_last (ex_last),
    .cyc     (cyc),
    .pulse   (pulse_idx),
    .cyc_end (cyc_end)
  );

  ucyc_iar_bank #(
    .NLVL(NLVL), .LW(LW), .AW(AW), .START_ADDR(START_ADDR)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lvl  (prog_level),
    .rd_data (iar_rd),
    .wr_en   (iar_wr_en),
    .wr_lvl  (iar_wr_lvl),
    .wr_data (iar_wr_data)
  );

  ucyc_fetch_dp #(
    .AW(AW), .DW(DW), .LW(LW)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc         (cyc),
    .cyc_end     (cyc_end),
    .prog_level  (prog_level),
    .iar_rd      (iar_rd),
    .src_rom     (src_rom),
    .mem_rdata   (mem_rdata),
    .ex_rd       (ex_rd),
    .ex_addr     (ex_addr),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_rom_sel (mem_rom_sel),
    .op_reg      (op_reg),
    .wb_en       (iar_wr_en),
    .wb_lvl      (iar_wr_lvl),
    .wb_data     (iar_wr_data)
  );

  assign cyc_code = cyc;

endmodule

// File: tb/tb_ucyc_seq.sv
`timescale 1ns/1ps
module tb_ucyc_seq;

  localparam logic [15:0] START = 16'hFFFA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  prog_level = '0;
  logic        src_rom = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        ex_long = 1'b0;
  logic        ex_last = 1'b0;
  logic        ex_rd = 1'b0;
  logic [15:0] ex_addr = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_rom_sel;
  logic [15:0] op_reg;
  logic [2:0]  cyc_code;
  logic [2:0]  pulse_idx;
  logic        iar_wr_en;
  logic [1:0]  iar_wr_lvl;
  logic [15:0] iar_wr_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_iar [4];

  always #4 clk = ~clk;

  ucyc_seq #(.START_ADDR(START)) dut (
    .clk(clk), .rst_n(rst_n), .prog_level(prog_level), .src_rom(src_rom),
    .mem_rdata(mem_rdata), .ex_long(ex_long), .ex_last(ex_last), .ex_rd(ex_rd),
    .ex_addr(ex_addr), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rom_sel(mem_rom_sel),
    .op_reg(op_reg), .cyc_code(cyc_code), .pulse_idx(pulse_idx), .iar_wr_en(iar_wr_en),
    .iar_wr_lvl(iar_wr_lvl), .iar_wr_data(iar_wr_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ex_last = 1'b0; ex_rd = 1'b0; src_rom = 1'b0; prog_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < 4; l++) m_iar[l] = START;
    #1;
  endtask

  // One full instruction: fetch cycles, then execute cycles of lengths lng[k].
  // last_at = execute cycle (1-based) carrying ex_last, 0 = never raised.
  task automatic run_instr(input int lvl, input logic rom, input logic [15:0] word,
                           input logic [4:0] lng, input int last_at);
    logic [15:0] a;
    int nx;
    int len;
    a  = m_iar[lvl];
    nx = (last_at > 0) ? last_at : 5;
    prog_level = 2'(lvl); src_rom = rom; mem_rdata = word;
    ex_rd = 1'b0; ex_last = 1'b0;
    #1;
    for (int p = 0; p < 3; p++) begin
      chk("R2", "F1 code", 32'(cyc_code), 0);
      chk("R2", "F1 pulse", 32'(pulse_idx), 32'(p));
      @(negedge clk); #1;
    end
    prog_level = 2'(lvl + 1);   // must not affect this fetch (R5)
    #1;
    for (int p = 0; p < 8; p++) begin
      chk("R2", "F2 code", 32'(cyc_code), 1);
      chk("R2", "F2 pulse", 32'(pulse_idx), 32'(p));
      chk("R3", "F2 mem_addr", 32'(mem_addr), 32'(a));
      chk("R3", "F2 mem_rd", 32'(mem_rd), 1);
      chk("R4", "F2 rom sel", 32'(mem_rom_sel), 32'(rom));
      @(negedge clk); #1;
    end
    for (int p = 0; p < 3; p++) begin
      chk("R2", "F3 code", 32'(cyc_code), 2);
      chk("R2", "F3 pulse", 32'(pulse_idx), 32'(p));
      chk("R4", "op_reg", 32'(op_reg), 32'(word));
      chk("R5", "wr_en", 32'(iar_wr_en), (p == 2) ? 1 : 0);
      if (p == 2) begin
        chk("R5", "wr_data", 32'(iar_wr_data), 32'(16'(a + 16'd2)));
        chk("R5", "wr_lvl", 32'(iar_wr_lvl), 32'(lvl));
        ex_long = lng[0];
      end
      @(negedge clk); #1;
    end
    m_iar[lvl] = 16'(a + 16'd2);
    src_rom = 1'b1; ex_rd = 1'b1; ex_addr = a ^ 16'h5A5A;
    #1;
    for (int k = 0; k < nx; k++) begin
      len = lng[k] ? 8 : 3;
      for (int p = 0; p < len; p++) begin
        chk("R6", "X code", 32'(cyc_code), 32'(3 + k));
        chk("R6", "X pulse", 32'(pulse_idx), 32'(p));
        chk("R9", "X rom sel", 32'(mem_rom_sel), 0);
        chk("R9", "X mem_addr", 32'(mem_addr), 32'(ex_addr));
        chk("R9", "X mem_rd", 32'(mem_rd), 1);
        if (p == len - 1) begin
          ex_last = (k + 1 == last_at);
          if (k < 4) ex_long = lng[k + 1];
        end
        @(negedge clk); #1;
      end
    end
    ex_last = 1'b0; ex_rd = 1'b0; src_rom = 1'b0;
    #1;
    chk((last_at > 0) ? "R7" : "R8", "end code", 32'(cyc_code), 0);
    chk((last_at > 0) ? "R7" : "R8", "end pulse", 32'(pulse_idx), 0);
    chk("R9", "F1 mem_rd", 32'(mem_rd), 0);
  endtask

  task automatic t_reset();
    chk("R1", "code", 32'(cyc_code), 0);
    chk("R1", "pulse", 32'(pulse_idx), 0);
    chk("R1", "op_reg", 32'(op_reg), 0);
    chk("R1", "wr_en", 32'(iar_wr_en), 0);
    chk("R1", "mem_rd", 32'(mem_rd), 0);
  endtask

  task automatic t_basic();
    run_instr(0, 1'b0, 16'h1234, 5'b00000, 1);
  endtask

  task automatic t_lengths();
    run_instr(0, 1'b1, 16'hBEEF, 5'b01101, 4);
    run_instr(1, 1'b0, 16'h0F0F, 5'b00010, 2);
  endtask

  task automatic t_forced();
    run_instr(1, 1'b0, 16'hA5A5, 5'b11111, 0);
    run_instr(2, 1'b1, 16'h5A5A, 5'b00000, 0);
  endtask

  task automatic t_levels();
    // R10: level 0 resumes from its own address after other levels ran.
    run_instr(2, 1'b0, 16'h7777, 5'b00001, 1);
    run_instr(0, 1'b0, 16'h8888, 5'b00000, 1);
    chk("R10", "level0 model", 32'(m_iar[0]), 32'(16'h0000));
  endtask

  task automatic t_wrap();
    // R5: level 3 from 0xFFFA; fourth fetch is at 0x0000 after the wrap.
    for (int i = 0; i < 4; i++) run_instr(3, 1'b0, 16'(16'h3000 + i), 5'b00000, 1);
    chk("R5", "wrap model", 32'(m_iar[3]), 32'(16'h0002));
  endtask

  task automatic t_reset_mid();
    prog_level = 2'd1; mem_rdata = 16'hCAFE;
    repeat (6) @(negedge clk);
    do_reset();
    t_reset();
    run_instr(1, 1'b0, 16'h4242, 5'b00000, 1);  // R1: level 1 back at START
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_basic();
    t_lengths();
    t_forced();
    t_levels();
    t_wrap();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule